// File: doc/BRIEF.md
# Run-Length Codeword Expander for Scan Loading

This block turns a serial stream of compressed test data back into the raw bit stream that fills a scan chain. Each compressed codeword describes one run of zeros that is closed by a single one. A codeword has two halves of equal length: a group marker (some ones, then a zero) and an index of the same width. The group gives the base run length, and the index is added to it.

Encoded bits come from a slow tester. The tester rate is modelled as a clock enable (`tick_en`) inside the single scan-rate clock domain, and every transfer uses a valid/ready handshake. Decoded bits leave at the full clock rate, at most one per cycle, each marked by `out_valid`. Zeros owed by the group marker are emitted while the rest of the codeword is still arriving.

Top module: `fdr_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `err` are 0, and the block waits for the first marker bit.
- R2: A codeword for run length L yields exactly L output bits of value 0 followed by one bit of value 1, in that order, at most one per clock. A 1 is emitted only after every owed 0 has left.
- R3: Group 1 codewords: bits `00` decode to run 0 and bits `01` decode to run 1 (first bit received first).
- R4: Group 2 codewords: `1000` decodes to run 2 and `1011` decodes to run 5.
- R5: Group 3 codewords: `110000` decodes to run 6 and `110111` decodes to run 13.
- R6: In general, a group-k codeword is k−1 ones, a zero, then a k-bit index j sent most significant bit first, and it decodes to run length 2^k − 2 + j. Codewords may follow one another with no gap.
- R7: A bit is consumed only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in every cycle where `tick_en` is 0.
- R8: From the cycle after the last index bit is consumed until the closing 1 has been emitted, `in_ready` stays 0.
- R9: A KMAX-th consecutive marker one (KMAX = 8 by default) sets `err`, which stays 1 until reset. The zeros already owed, 2^KMAX − 2 in total, are still emitted.
- R10: Zero output overlaps input: zeros owed by the marker start to appear before the codeword's last index bit has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse for each tester-rate slot |
| in_valid | input | 1 | Tester offers an encoded bit |
| in_bit | input | 1 | Encoded bit value |
| in_ready | output | 1 | Block takes the offered bit this cycle |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded bit value |
| err | output | 1 | Sticky marker-overflow flag |

## Verification
Two actions can fall in the same cycle: emitting an owed zero and consuming a new encoded bit that adds more owed zeros or completes the index. This is provoked by sending group-3 and longer codewords with `tick_en` pulsing every fourth cycle, so each accepted bit lands while earlier zeros are still draining. The result is judged by a scoreboard that compares every output bit, in order, against the expected run, and by checking that output has started before the final index bit and that `in_ready` is low at the next tester slot after that bit.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
    typedef enum logic [1:0] {
        ST_PREFIX = 2'd0,
        ST_TAIL   = 2'd1,
        ST_FLUSH  = 2'd2
    } fdr_state_e;
endpackage

// File: rtl/fdr_zero_pool.sv
// Counts zeros that are owed to the scan output but not yet emitted.
module fdr_zero_pool #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic [PW-1:0] add_val,
    input  logic          take,
    output logic          empty
);
    logic [PW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (take)   count_d = count_d - PW'(1);
        if (add_en) count_d = count_d + add_val;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign empty = (count_q == '0);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (count_q != '0));
endmodule

// File: rtl/fdr_tail_shift.sv
// Collects the index half of a codeword, most significant bit first.
module fdr_tail_shift #(
    parameter int KMAX = 8,
    parameter int GW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            bit_in,
    input  logic [GW-1:0]   len,
    output logic            last,
    output logic [KMAX-1:0] idx_next
);
    typedef struct packed {
        logic [GW-1:0]   cnt;
        logic [KMAX-1:0] idx;
    } sh_t;

    sh_t s_d, s_q;

    assign idx_next = {s_q.idx[KMAX-2:0], bit_in};
    assign last     = (s_q.cnt == len - GW'(1));

    always_comb begin
        s_d = s_q;
        if (load) begin
            if (last) begin
                s_d.cnt = '0;
                s_d.idx = '0;
            end else begin
                s_d.cnt = s_q.cnt + GW'(1);
                s_d.idx = idx_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R6
    tail_len_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (s_q.cnt < len));
endmodule

// File: rtl/fdr_decoder.sv
module fdr_decoder
    import fdr_pkg::*;
#(
    parameter int KMAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic err
);
    localparam int GW = $clog2(KMAX + 1);
    localparam int PW = KMAX + 2;

    typedef struct packed {
        fdr_state_e    state;
        logic [GW-1:0] grp;
        logic          err;
        logic          ov;
        logic          ob;
    } regs_t;

    regs_t r_d, r_q;

    logic          acc;
    logic          take;
    logic          pool_empty;
    logic          add_en;
    logic [PW-1:0] add_val;
    logic          sh_load;
    logic          sh_last;
    logic [KMAX-1:0] sh_next;

    fdr_zero_pool #(.PW(PW)) pool_i (
        .clk     (clk),
        .rst     (rst),
        .add_en  (add_en),
        .add_val (add_val),
        .take    (take),
        .empty   (pool_empty)
    );

    fdr_tail_shift #(.KMAX(KMAX), .GW(GW)) tail_i (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .bit_in   (in_bit),
        .len      (r_q.grp),
        .last     (sh_last),
        .idx_next (sh_next)
    );

    always_comb begin
        r_d      = r_q;
        in_ready = tick_en && (r_q.state != ST_FLUSH);
        acc      = in_valid && in_ready;
        take     = !pool_empty;
        add_en   = 1'b0;
        add_val  = '0;
        sh_load  = 1'b0;
        r_d.ov   = 1'b0;
        r_d.ob   = 1'b0;

        // output side: one bit per clock
        if (take) begin
            r_d.ov = 1'b1;
            r_d.ob = 1'b0;
        end else if (r_q.state == ST_FLUSH) begin
            r_d.ov    = 1'b1;
            r_d.ob    = 1'b1;
            r_d.state = ST_PREFIX;
        end

        // input side: consume at tester rate
        unique case (r_q.state)
            ST_PREFIX: begin
                if (acc) begin
                    if (in_bit) begin
                        if (r_q.grp == GW'(KMAX)) begin
                            r_d.err = 1'b1;
                        end else begin
                            add_en  = 1'b1;
                            add_val = PW'(1) << r_q.grp;
                            r_d.grp = r_q.grp + GW'(1);
                        end
                    end else begin
                        r_d.state = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (acc) begin
                    sh_load = 1'b1;
                    if (sh_last) begin
                        add_en    = 1'b1;
                        add_val   = PW'(sh_next);
                        r_d.state = ST_FLUSH;
                        r_d.grp   = GW'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_PREFIX;
            r_q.grp   <= GW'(1);
            r_q.err   <= 1'b0;
            r_q.ov    <= 1'b0;
            r_q.ob    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ov;
    assign out_bit   = r_q.ob;
    assign err       = r_q.err;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R2
    one_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bit) |-> $past(pool_empty));

    // R2
    one_ends_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bit) |-> (r_q.state == ST_PREFIX));

    // R8
    flush_block_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && r_q.state == ST_TAIL && sh_last) |=> !in_ready);
endmodule

// File: tb/fdr_decoder_tb_top.sv
module fdr_decoder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, out_valid, out_bit, err;
    logic [1:0] tcnt;

    int checks = 0;
    int errors = 0;
    int out_cnt = 0;
    bit exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tcnt <= 2'd0;
        else     tcnt <= tcnt + 2'd1;
    end
    assign tick_en = (tcnt == 2'd3);

    fdr_decoder dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
        .out_valid(out_valid), .out_bit(out_bit), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            out_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected output bit", int'(out_bit), -1);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(out_bit == e, "R2", "output bit", int'(out_bit), int'(e));
            end
        end
    end

    task automatic push_run(input int len);
        for (int i = 0; i < len; i++) exp_q.push_back(1'b0);
        exp_q.push_back(1'b1);
    endtask

    task automatic send_bit(input bit b);
        in_valid = 1'b1;
        in_bit   = b;
        while (1) begin
            #1;
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1");
    endtask

    function automatic string encode(input int len);
        int k = 1;
        int j;
        string s = "";
        while (len > (1 << (k + 1)) - 3) k++;
        j = len - ((1 << k) - 2);
        for (int i = 0; i < k - 1; i++) s = {s, "1"};
        s = {s, "0"};
        for (int i = k - 1; i >= 0; i--) s = {s, (((j >> i) & 1) != 0) ? "1" : "0"};
        return s;
    endfunction

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_code(input int len, input string code);
        push_run(len);
        send_str(code);
    endtask

    initial begin
        fork
            begin
                int mark;
                repeat (3) @(negedge clk);
                chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
                chk(err == 1'b0, "R1", "err in reset", int'(err), 0);
                rst = 1'b0;
                @(negedge clk);
                chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
                // R7: ready gated by tester slot
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk); #1;
                    if (!tick_en)
                        chk(in_ready == 1'b0, "R7", "ready without tick", int'(in_ready), 0);
                    else
                        chk(in_ready == 1'b1, "R1", "ready in idle slot", int'(in_ready), 1);
                end
                @(negedge clk);
                // R3
                run_code(0, "00");
                run_code(1, "01");
                wait_idle();
                // R4
                run_code(2, "1000");
                run_code(5, "1011");
                wait_idle();
                // R5, R10, R8
                run_code(6, "110000");
                wait_idle();
                push_run(13);
                mark = out_cnt;
                send_str("11011");
                chk(out_cnt > mark, "R10", "zeros before last tail bit", out_cnt - mark, 1);
                send_bit(1'b1);
                while (1) begin
                    #1;
                    if (tick_en) break;
                    chk(in_ready == 1'b0, "R7", "ready without tick", int'(in_ready), 0);
                    @(negedge clk);
                end
                chk(in_ready == 1'b0, "R8", "ready during flush", int'(in_ready), 0);
                @(negedge clk);
                wait_idle();
                // R6: back-to-back general stream
                for (int len = 0; len <= 40; len++) run_code(len, encode(len));
                run_code(200, encode(200));
                wait_idle();
                chk(exp_q.size() == 0, "R6", "stream drained", exp_q.size(), 0);
                // R9: overlong marker
                for (int i = 0; i < 254; i++) exp_q.push_back(1'b0);
                send_str("11111111");
                repeat (3) @(negedge clk);
                chk(err == 1'b1, "R9", "err after overlong marker", int'(err), 1);
                wait_idle();
                chk(err == 1'b1, "R9", "err stays set", int'(err), 1);
                chk(exp_q.size() == 0, "R9", "owed zeros emitted", exp_q.size(), 0);
                rst = 1'b1;
                repeat (2) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                chk(err == 1'b0, "R1", "err cleared by reset", int'(err), 0);
                run_code(1, "01");
                wait_idle();
                chk(exp_q.size() == 0, "R3", "recovery decode", exp_q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog R2 actual %0d expected %0d", 1, 0);
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule